// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block decodes the two-port indirect scheme that reaches configuration space over a byte-addressable I/O bus. Software first writes a 32-bit address word into the address port. That word picks a bus, a device, a function and a dword register. Software then moves data through a four-byte data window. The block keeps a small set of attached function slots, and each slot owns a fixed bus/device/function number and a run of configuration dwords.

Writing the top byte of the address port starts a lookup. The lookup stores a status word and a response dword. Later reads of the data window return the response, and reads of the address port return the status. Writes through the data window go to the slot the latch currently selects, and only to the byte lanes that the access covers. One write pattern on address byte 1 does not update the latch. Instead it asks the rest of the chip for a hard reset.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset, a dword read of the address port returns 0x00000000, a dword read of the data window returns 0xFFFFFFFF, and `reset_req` is 0.
- R2: `io_addr` values 0 to 3 select byte 0 to 3 of the address port, and values 4 to 7 select byte 0 to 3 of the data window. A write that covers address byte 0 always stores bits 1:0 of the latch as zero.
- R3: The latch fields are: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword register. A lookup on bits 23:8 runs only when an address-port write covers byte 3.
- R4: A lookup that matches a slot sets the status to 0x80000000 and the response to the stored dword at the register index.
- R5: A lookup that matches a slot with a register index of `SLOT_DWORDS` or more returns a response of 0. The status is still 0x80000000.
- R6: A lookup that matches no slot sets the response to 0xFFFFFFFF and the status to 0.
- R7: `io_size` 0 is a byte, 1 a word and 2 a dword. A byte at offset k writes lane k, a word at offset 0 or 2 writes two lanes from there, and a dword is allowed only at offset 0. Every other size/offset combination, including size 3, writes nothing.
- R8: A data-window write is dropped when the latched bus/device/function matches no slot, or when the register index is `SLOT_DWORDS` or more.
- R9: A write that covers address byte 1 with data bits 2:1 equal to 11, while latch bits 10:9 equal 01, leaves latch byte 1 unchanged. It raises `reset_req` for exactly the next cycle. No other write raises it.
- R10: `io_rdata` returns the selected word (status for the address port, response for the data window) shifted right by 8 times the offset. It is masked to 8 bits for size 0 and 16 bits for size 1, and is left unmasked for sizes 2 and 3.
- R11: Data-window writes never change the response, the status or the latch. The response changes only at the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Port select: 0-3 address port byte, 4-7 data window byte |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wr | input | 1 | Write strobe for this cycle |
| io_wdata | input | 32 | Write data, right-aligned |
| io_rdata | output | 32 | Read data for the current select and size |
| reset_req | output | 1 | One-cycle hard-reset request |

## Verification
The assertions assume that `io_wr` is low whenever reset is held, and that the slot numbers are all different, so at most one slot can match. They also rely on each write coming in a single cycle. The stimulus follows all of this: it keeps `io_wr` at zero through reset, it gives the two slots distinct function numbers, and each write is one one-cycle strobe with a read select driven between strobes. It also drives misaligned and size-3 writes on purpose, because the block must drop them and keep its state.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] status;
        logic [31:0] resp;
        logic        rst_req;
    } state_t;

    localparam logic [31:0] STATUS_PRESENT = 32'h8000_0000;
    localparam logic [31:0] RESP_ABSENT    = 32'hFFFF_FFFF;

endpackage

// File: rtl/cfg_lane_decode.sv
module cfg_lane_decode (
    input  logic [1:0] size,
    input  logic [1:0] offset,
    output logic [3:0] be
);
    import cfg_pkg::*;

    always_comb begin
        be = 4'b0000;
        case (acc_size_e'(size))
            SZ_BYTE:  be = 4'b0001 << offset;
            SZ_WORD:  be = offset[0] ? 4'b0000 : (4'b0011 << offset);
            SZ_DWORD: be = (offset == 2'd0) ? 4'b1111 : 4'b0000;
            default:  be = 4'b0000;
        endcase
    end
endmodule

// File: rtl/cfg_slot_store.sv
module cfg_slot_store #(
    parameter logic [15:0] BDF_ID = 16'h0000,
    parameter int          DWORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] q_bdf,
    input  logic [5:0]  q_reg,
    output logic        q_hit,
    output logic [31:0] q_data,
    input  logic        w_en,
    input  logic [15:0] w_bdf,
    input  logic [5:0]  w_reg,
    input  logic [3:0]  w_be,
    input  logic [31:0] w_data
);
    localparam int         IDX_W = (DWORDS > 1) ? $clog2(DWORDS) : 1;
    localparam logic [6:0] LIMIT = 7'(DWORDS);

    logic [31:0] mem_q [DWORDS];
    logic [31:0] mem_d [DWORDS];
    logic        q_in_range;
    logic        w_sel;

    always_comb begin
        q_hit      = (q_bdf == BDF_ID);
        q_in_range = ({1'b0, q_reg} < LIMIT);
        q_data     = q_in_range ? mem_q[q_reg[IDX_W-1:0]] : 32'h0;
        w_sel      = w_en && (w_bdf == BDF_ID) && ({1'b0, w_reg} < LIMIT);
    end

    always_comb begin
        mem_d = mem_q;
        if (w_sel) begin
            for (int b = 0; b < 4; b++) begin
                if (w_be[b]) begin
                    mem_d[w_reg[IDX_W-1:0]][8*b +: 8] = w_data[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DWORDS; i++) begin
                mem_q[i] <= 32'h0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
    parameter int                     NUM_SLOTS   = 2,
    parameter logic [NUM_SLOTS*16-1:0] SLOT_BDF   = 32'h000A_0000,
    parameter int                     SLOT_DWORDS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  io_addr,
    input  logic [1:0]  io_size,
    input  logic        io_wr,
    input  logic [31:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        reset_req
);
    import cfg_pkg::*;

    state_t      state_q, state_d;
    logic [3:0]  be;
    logic [31:0] wsh;
    logic [31:0] addr_nx;
    logic        rst_nx;
    logic        query_go;
    logic [NUM_SLOTS-1:0] hit_vec;
    logic [31:0] slot_data [NUM_SLOTS];
    logic        any_hit;
    logic [31:0] hit_data;
    logic [31:0] rd_word;
    logic [31:0] rd_shift;

    cfg_lane_decode u_lane (
        .size   (io_size),
        .offset (io_addr[1:0]),
        .be     (be)
    );

    assign wsh = io_wdata << {io_addr[1:0], 3'b000};

    // Address-port byte handling and reset-sequence detection.
    always_comb begin
        addr_nx  = state_q.addr;
        rst_nx   = 1'b0;
        query_go = 1'b0;
        if (io_wr && !io_addr[2]) begin
            if (be[0]) addr_nx[7:0] = {wsh[7:2], 2'b00};
            if (be[1]) begin
                if (wsh[10:9] == 2'b11 && state_q.addr[10:9] == 2'b01) begin
                    rst_nx = 1'b1;
                end else begin
                    addr_nx[15:8] = wsh[15:8];
                end
            end
            if (be[2]) addr_nx[23:16] = wsh[23:16];
            if (be[3]) addr_nx[31:24] = wsh[31:24];
            query_go = be[3];
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        cfg_slot_store #(
            .BDF_ID (SLOT_BDF[s*16 +: 16]),
            .DWORDS (SLOT_DWORDS)
        ) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .q_bdf  (addr_nx[23:8]),
            .q_reg  (addr_nx[7:2]),
            .q_hit  (hit_vec[s]),
            .q_data (slot_data[s]),
            .w_en   (io_wr && io_addr[2]),
            .w_bdf  (state_q.addr[23:8]),
            .w_reg  (state_q.addr[7:2]),
            .w_be   (be),
            .w_data (wsh)
        );
    end

    always_comb begin
        any_hit  = |hit_vec;
        hit_data = 32'h0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (hit_vec[s]) hit_data = hit_data | slot_data[s];
        end
    end

    always_comb begin
        state_d         = state_q;
        state_d.addr    = addr_nx;
        state_d.rst_req = rst_nx;
        if (query_go) begin
            state_d.status = any_hit ? STATUS_PRESENT : 32'h0;
            state_d.resp   = any_hit ? hit_data : RESP_ABSENT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.addr    <= 32'h0;
            state_q.status  <= 32'h0;
            state_q.resp    <= RESP_ABSENT;
            state_q.rst_req <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rd_word  = io_addr[2] ? state_q.resp : state_q.status;
        rd_shift = rd_word >> {io_addr[1:0], 3'b000};
        case (acc_size_e'(io_size))
            SZ_BYTE: io_rdata = {24'h0, rd_shift[7:0]};
            SZ_WORD: io_rdata = {16'h0, rd_shift[15:0]};
            default: io_rdata = rd_shift;
        endcase
    end

    assign reset_req = state_q.rst_req;
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      io_addr,
    input logic [1:0]      io_size,
    input logic            io_wr,
    input logic            reset_req,
    input cfg_pkg::state_t state_q
);
    logic cov1, cov3;
    assign cov1 = (io_size == 2'd0 && io_addr[1:0] == 2'd1) ||
                  (io_size == 2'd1 && io_addr[1:0] == 2'd0) ||
                  (io_size == 2'd2 && io_addr[1:0] == 2'd0);
    assign cov3 = (io_size == 2'd0 && io_addr[1:0] == 2'd3) ||
                  (io_size == 2'd1 && io_addr[1:0] == 2'd2) ||
                  (io_size == 2'd2 && io_addr[1:0] == 2'd0);

    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.addr[1:0] == 2'b00);

    a_r3_lookup_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(state_q.resp) || !$stable(state_q.status)) |->
        $past(io_wr && !io_addr[2] && cov3));

    a_r4_status_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.status == 32'h0 || state_q.status == 32'h8000_0000);

    a_r6_absent_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.status == 32'h0 |-> state_q.resp == 32'hFFFF_FFFF);

    a_r9_reset_source: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(io_wr && !io_addr[2] && cov1));

    a_r9_latch_held: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> state_q.addr[15:8] == $past(state_q.addr[15:8]));

    a_r11_data_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $past(io_wr && io_addr[2]) |-> $stable(state_q.addr) && $stable(state_q.resp));
endmodule

bind cfg_port_decoder cfg_port_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_size   (io_size),
    .io_wr     (io_wr),
    .reset_req (reset_req),
    .state_q   (state_q)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  io_addr = 3'd0;
    logic [1:0]  io_size = 2'd0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = 32'h0;
    logic [31:0] io_rdata;
    logic        reset_req;

    int checks = 0;
    int errors = 0;

    localparam int DW = 16;
    logic [15:0] slot_id [2] = '{16'h0000, 16'h000A};

    logic [31:0] m_addr, m_status, m_resp;
    logic        m_rst;
    logic [31:0] m_mem [2][DW];

    cfg_port_decoder #(
        .NUM_SLOTS   (2),
        .SLOT_BDF    (32'h000A_0000),
        .SLOT_DWORDS (DW)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_addr   (io_addr),
        .io_size   (io_size),
        .io_wr     (io_wr),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .reset_req (reset_req)
    );

    always #2.5 clk = ~clk;

    function automatic int find_slot(logic [15:0] b);
        for (int i = 0; i < 2; i++) if (slot_id[i] == b) return i;
        return -1;
    endfunction

    function automatic logic [3:0] lanes(logic [1:0] sz, logic [1:0] off);
        if (sz == 2'd0) return 4'b0001 << off;
        if (sz == 2'd1) return off[0] ? 4'b0000 : (4'b0011 << off);
        if (sz == 2'd2) return (off == 2'd0) ? 4'b1111 : 4'b0000;
        return 4'b0000;
    endfunction

    function automatic logic [31:0] model_read();
        logic [31:0] w;
        w = io_addr[2] ? m_resp : m_status;
        w = w >> (8 * io_addr[1:0]);
        if (io_size == 2'd0) return w & 32'hFF;
        if (io_size == 2'd1) return w & 32'hFFFF;
        return w;
    endfunction

    // Behavioural reference, updated on each rising edge.
    always @(posedge clk) begin : model
        logic [31:0] d;
        logic [3:0]  ln;
        int          sl;
        int          ix;
        if (!rst_n) begin
            m_addr = 0; m_status = 0; m_resp = 32'hFFFF_FFFF; m_rst = 0;
            for (int i = 0; i < 2; i++) for (int j = 0; j < DW; j++) m_mem[i][j] = 0;
        end else begin
            m_rst = 0;
            if (io_wr) begin
                d  = io_wdata << (8 * io_addr[1:0]);
                ln = lanes(io_size, io_addr[1:0]);
                if (!io_addr[2]) begin
                    if (ln[0]) m_addr[7:0] = d[7:0] & 8'hFC;
                    if (ln[1]) begin
                        if (d[10:9] == 2'b11 && m_addr[10:9] == 2'b01) m_rst = 1;
                        else m_addr[15:8] = d[15:8];
                    end
                    if (ln[2]) m_addr[23:16] = d[23:16];
                    if (ln[3]) begin
                        m_addr[31:24] = d[31:24];
                        sl = find_slot(m_addr[23:8]);
                        ix = int'(m_addr[7:2]);
                        if (sl < 0) begin m_status = 0; m_resp = 32'hFFFF_FFFF; end
                        else begin
                            m_status = 32'h8000_0000;
                            m_resp = (ix < DW) ? m_mem[sl][ix] : 32'h0;
                        end
                    end
                end else begin
                    sl = find_slot(m_addr[23:8]);
                    ix = int'(m_addr[7:2]);
                    if (sl >= 0 && ix < DW)
                        for (int b = 0; b < 4; b++)
                            if (ln[b]) m_mem[sl][ix][8*b +: 8] = d[8*b +: 8];
                end
            end
        end
    end

    // Per-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (io_rdata !== model_read()) begin
                errors++;
                $display("FAIL R10 per-cycle rdata actual=%h expected=%h", io_rdata, model_read());
            end
            checks++;
            if (reset_req !== m_rst) begin
                errors++;
                $display("FAIL R9 per-cycle reset_req actual=%b expected=%b", reset_req, m_rst);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(posedge clk); #1;
        io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, input logic [31:0] exp,
                      input string tag);
        @(posedge clk); #1;
        io_addr = a; io_size = s; io_wr = 1'b0;
        @(negedge clk);
        check(tag, io_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset_req", {31'h0, reset_req}, 32'h0);
        rd(3'd0, 2'd2, 32'h0, "R1 status after reset");
        rd(3'd4, 2'd2, 32'hFFFF_FFFF, "R1 response after reset");

        // R2: low bits forced to zero; slot at dev1 fn2 register 2
        wr(3'd0, 2'd2, 32'h8000_0A0B);
        rd(3'd0, 2'd2, 32'h8000_0000, "R4 status present");
        wr(3'd4, 2'd2, 32'hA1B2_C3D4);
        rd(3'd4, 2'd2, 32'h0, "R11 response unchanged by data write");
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd4, 2'd2, 32'hA1B2_C3D4, "R4 stored dword via R2 aligned latch");
        rd(3'd5, 2'd0, 32'hC3, "R10 byte read at offset 1");
        rd(3'd6, 2'd1, 32'hA1B2, "R10 word read at offset 2");
        rd(3'd4, 2'd3, 32'hA1B2_C3D4, "R10 size 3 reads as dword");

        // R7: lane writes and dropped misaligned ones
        wr(3'd5, 2'd0, 32'h55);
        wr(3'd6, 2'd1, 32'h6677);
        wr(3'd5, 2'd1, 32'hEEEE);
        wr(3'd6, 2'd2, 32'h9999_9999);
        wr(3'd4, 2'd3, 32'h1111_1111);
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd4, 2'd2, 32'h6677_55D4, "R7 lane merge");

        // R6/R8: absent device and bus
        wr(3'd0, 2'd2, 32'h8000_1000);
        rd(3'd4, 2'd2, 32'hFFFF_FFFF, "R6 absent response");
        rd(3'd0, 2'd2, 32'h0, "R6 absent status");
        wr(3'd4, 2'd2, 32'h1234_5678);
        wr(3'd0, 2'd2, 32'h8001_0A08);
        rd(3'd4, 2'd2, 32'hFFFF_FFFF, "R3 bus field selects absent");
        wr(3'd0, 2'd2, 32'h8000_0A08);
        rd(3'd4, 2'd2, 32'h6677_55D4, "R8 absent write dropped");

        // R5/R8: beyond implemented space, and the last implemented dword
        wr(3'd0, 2'd2, 32'h8000_0050);
        wr(3'd4, 2'd2, 32'hDEAD_BEEF);
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd4, 2'd2, 32'h0, "R5 beyond range reads zero");
        rd(3'd0, 2'd2, 32'h8000_0000, "R5 status present");
        wr(3'd0, 2'd2, 32'h8000_003C);
        wr(3'd4, 2'd2, 32'h1122_3344);
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd4, 2'd2, 32'h1122_3344, "R5 last implemented dword");

        // R3: lower-byte write alone does not launch a lookup
        wr(3'd2, 2'd0, 32'h01);
        rd(3'd4, 2'd2, 32'h1122_3344, "R3 no lookup without byte 3");

        // R9: reset sequence, latch byte 1 is 0x0A (bits 2:1 = 01)
        wr(3'd0, 2'd2, 32'h8000_0A08);
        wr(3'd1, 2'd0, 32'h0E);
        @(negedge clk);
        check("R9 pulse raised", {31'h0, reset_req}, 32'h1);
        @(negedge clk);
        check("R9 pulse ends", {31'h0, reset_req}, 32'h0);
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd4, 2'd2, 32'h6677_55D4, "R9 latch byte 1 kept");

        // R9: pattern without the 01 precondition just latches
        wr(3'd0, 2'd2, 32'h8000_0000);
        wr(3'd1, 2'd0, 32'h06);
        @(negedge clk);
        check("R9 no pulse", {31'h0, reset_req}, 32'h0);
        wr(3'd3, 2'd0, 32'h80);
        rd(3'd0, 2'd2, 32'h0, "R9 byte 1 latched to absent fn");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule